// File: doc/BRIEF.md
# Sensor line and frame sync generator

This block produces the horizontal and vertical sync timing for an image sensor readout. It keeps a pixel counter and a line counter, both clocked by the master pixel clock. From these it derives an active-low horizontal sync (`hd_n_o`) at the start of every line and an active-low vertical sync (`vd_n_o`) for the whole first line of each field. A small write-only register port sets the timing. The line length is written in Gray code with an offset of four pixels. The field length is written in plain binary. The horizontal sync width and the operating mode are also set through this port.

After reset the block is a slave. The external image processor supplies horizontal and vertical syncs on `hd_n_i` and `vd_n_i`. A falling edge on either one realigns the internal counters. In master mode the block's own counters define the timing, and `hv_drive_o` tells the board to take HD and VD from this block. In either mode, a rising edge on the `sync_i` pulse restarts both counters from the top of a field. That pulse may arrive from an unrelated clock domain. A new line length or field length takes effect only at the next field start, so a line is never cut short.

Top module: `sensor_sync_gen`

## Requirements
- R1: While reset is held and right after it, the block is in slave mode (`hv_drive_o`=0), both counters read 0, and `hd_n_o` and `vd_n_o` are both low.
- R2: A line is G+4 pixels long, where G is the binary value of the 12-bit Gray word written to register address 0. Binary bit i is the XOR of Gray bits i through 11. The pixel counter counts 0 up to G+3 and then returns to 0. For example, the word 0x51E gives 1560 pixels.
- R3: The line counter advances by one at every line end. After the last line of a field it returns to 0. The number of lines per field is the binary value at address 1, and 0 is treated as 1.
- R4: `hd_n_o` is low while the pixel counter is below W and high otherwise. W is bits 3:0 at address 2, 0 is treated as 1, and a write to this address takes effect on the next cycle.
- R5: `vd_n_o` is low exactly while the line counter is 0.
- R6: Bit 0 at address 3 selects master mode (1) or slave mode (0). `hv_drive_o` follows that bit from the cycle after the write.
- R7: In slave mode, a falling edge on `hd_n_i` resets the pixel counter to 0 and advances the line counter as a line end does. Counting resumes from there. A rising edge has no effect.
- R8: In slave mode, a falling edge on `vd_n_i` resets both counters to 0.
- R9: A rising edge on `sync_i` resets both counters to 0 in either mode. It wins over a normal line end and over a slave HD edge that fall in the same cycle.
- R10: Writes to addresses 0 and 1 take effect only at the next field start. A field start is a wrap of the last line, a SYNC edge, a slave VD edge, or a slave HD edge on the last line.
- R11: When G+3 exceeds 4095, the line length saturates at 4096 pixels. For example, the Gray word 0x800 gives 4096 pixels.
- R12: `hd_n_i`, `vd_n_i` and `sync_i` each pass through a two-flop synchronizer. An input level first sampled at clock edge E takes effect on the counters at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 line Gray, 1 field lines, 2 HD width, 3 mode |
| cfg_wdata | input | 12 | Register write data |
| sync_i | input | 1 | Restart pulse, acted on at its rising edge |
| hd_n_i | input | 1 | External horizontal sync, slave mode |
| vd_n_i | input | 1 | External vertical sync, slave mode |
| hd_n_o | output | 1 | Generated horizontal sync, active low |
| vd_n_o | output | 1 | Generated vertical sync, active low |
| hv_drive_o | output | 1 | High in master mode: block drives HD/VD |
| pix_cnt_o | output | 12 | Current pixel position in the line |
| line_cnt_o | output | 12 | Current line position in the field |

## Verification
Mode and HD-width writes become visible after the one clock edge that captures them. Line and field lengths are checked only from the first field start that follows the write. A level placed on `sync_i`, `hd_n_i` or `vd_n_i` at a falling clock edge reaches the counters at the third rising edge after it. The bench therefore checks the cleared counters at the third falling edge after it sets the input. The sync outputs are combinational from the counters, so the bench walks an independent pixel/line model one step per falling edge and compares every cycle.

// File: rtl/sensor_sync_pkg.sv
package sensor_sync_pkg;
  // Register map of the timing port.
  typedef enum logic [1:0] {
    REG_LINE_GRAY = 2'd0,
    REG_FIELD_LEN = 2'd1,
    REG_HD_WIDTH  = 2'd2,
    REG_MODE      = 2'd3
  } sync_reg_e;
endpackage

// File: rtl/sg_edge_sync.sv
// Two-flop synchronizer followed by an edge detector; the edge kind is chosen by parameter.
module sg_edge_sync #(
  parameter logic IDLE    = 1'b0,
  parameter bit   ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic evt
);
  logic [2:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= {3{IDLE}};
    else        stage_q <= {stage_q[1:0], din};
  end

  generate
    if (ON_FALL) begin : g_fall
      assign evt = stage_q[2] & ~stage_q[1];
    end else begin : g_rise
      assign evt = ~stage_q[2] & stage_q[1];
    end
  endgenerate
endmodule

// File: rtl/sg_timing_regs.sv
// Holds written values in shadow registers and moves line/field lengths into
// the active set only at a field start.
module sg_timing_regs
  import sensor_sync_pkg::*;
#(
  parameter int          PIX_W         = 12,
  parameter int          LINE_W        = 12,
  parameter int          HDW_W         = 4,
  parameter int          CFG_W         = 12,
  parameter logic [11:0] DEF_LINE_GRAY = 12'h51E,
  parameter logic [11:0] DEF_FIELD     = 12'd262,
  parameter logic [3:0]  DEF_HDW       = 4'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              load,
  output logic [PIX_W-1:0]  pix_last,
  output logic [LINE_W-1:0] line_last,
  output logic [HDW_W-1:0]  hd_width,
  output logic              master
);
  function automatic logic [PIX_W-1:0] gray_to_bin(input logic [PIX_W-1:0] g);
    logic [PIX_W-1:0] b;
    b[PIX_W-1] = g[PIX_W-1];
    for (int i = PIX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Last pixel index: decoded + 3, saturated at the counter's top.
  function automatic logic [PIX_W-1:0] last_pixel(input logic [PIX_W-1:0] dec);
    logic [PIX_W:0] sum;
    sum = {1'b0, dec} + (PIX_W + 1)'(3);
    return sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
  endfunction

  function automatic logic [LINE_W-1:0] last_line(input logic [LINE_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [HDW_W-1:0] eff_width(input logic [HDW_W-1:0] w);
    return (w == '0) ? HDW_W'(1) : w;
  endfunction

  logic [PIX_W-1:0]  sh_line_gray_q;
  logic [LINE_W-1:0] sh_field_q;
  logic [PIX_W-1:0]  act_pix_last_q;
  logic [LINE_W-1:0] act_line_last_q;
  logic [HDW_W-1:0]  hdw_q;
  logic              master_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_line_gray_q <= PIX_W'(DEF_LINE_GRAY);
      sh_field_q     <= LINE_W'(DEF_FIELD);
      hdw_q          <= HDW_W'(DEF_HDW);
      master_q       <= 1'b0;
    end else if (we) begin
      case (sync_reg_e'(addr))
        REG_LINE_GRAY: sh_line_gray_q <= wdata[PIX_W-1:0];
        REG_FIELD_LEN: sh_field_q     <= wdata[LINE_W-1:0];
        REG_HD_WIDTH:  hdw_q          <= wdata[HDW_W-1:0];
        REG_MODE:      master_q       <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pix_last_q  <= last_pixel(gray_to_bin(PIX_W'(DEF_LINE_GRAY)));
      act_line_last_q <= last_line(LINE_W'(DEF_FIELD));
    end else if (load) begin
      act_pix_last_q  <= last_pixel(gray_to_bin(sh_line_gray_q));
      act_line_last_q <= last_line(sh_field_q);
    end
  end

  assign pix_last  = act_pix_last_q;
  assign line_last = act_line_last_q;
  assign hd_width  = eff_width(hdw_q);
  assign master    = master_q;
endmodule

// File: rtl/sg_counters.sv
// Pixel and line counters with restart, external line-step and natural wrap.
module sg_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              line_step,
  input  logic [PIX_W-1:0]  pix_last,
  input  logic [LINE_W-1:0] line_last,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              pix_wrap,
  output logic              frame_start
);
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              line_end;
  logic              at_last_line;

  assign pix_wrap     = (pix_q >= pix_last);
  assign line_end     = line_step | pix_wrap;
  assign at_last_line = (line_q >= line_last);
  assign frame_start  = clr_all | (line_end & at_last_line);

  // Priority: restart, then line end (external or natural), then count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (clr_all) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (line_end) begin
      pix_q  <= '0;
      line_q <= at_last_line ? '0 : line_q + 1'b1;
    end else begin
      pix_q  <= pix_q + 1'b1;
    end
  end

  assign pix_cnt  = pix_q;
  assign line_cnt = line_q;
endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen #(
  parameter int          PIX_W         = 12,
  parameter int          LINE_W        = 12,
  parameter int          HDW_W         = 4,
  parameter int          CFG_W         = 12,
  parameter logic [11:0] DEF_LINE_GRAY = 12'h51E,
  parameter logic [11:0] DEF_FIELD     = 12'd262,
  parameter logic [3:0]  DEF_HDW       = 4'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              sync_i,
  input  logic              hd_n_i,
  input  logic              vd_n_i,
  output logic              hd_n_o,
  output logic              vd_n_o,
  output logic              hv_drive_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o
);
  localparam int NUM_IN = 3;
  localparam logic [NUM_IN-1:0] IN_IDLE = 3'b110;   // {vd, hd, sync}
  localparam logic [NUM_IN-1:0] IN_FALL = 3'b110;

  // Named internal events, used by the checker.
  logic [NUM_IN-1:0] in_raw;
  logic [NUM_IN-1:0] in_evt;
  logic              sync_rise;
  logic              hd_evt;
  logic              vd_evt;
  logic              frame_start;
  logic              pix_wrap;
  logic              master;
  logic [PIX_W-1:0]  pix_last;
  logic [LINE_W-1:0] line_last;
  logic [HDW_W-1:0]  hd_width;

  assign in_raw = {vd_n_i, hd_n_i, sync_i};

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
      sg_edge_sync #(
        .IDLE   (IN_IDLE[gi]),
        .ON_FALL(IN_FALL[gi])
      ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_raw[gi]),
        .evt  (in_evt[gi])
      );
    end
  endgenerate

  assign sync_rise = in_evt[0];
  assign hd_evt    = in_evt[1] & ~master;
  assign vd_evt    = in_evt[2] & ~master;

  sg_timing_regs #(
    .PIX_W        (PIX_W),
    .LINE_W       (LINE_W),
    .HDW_W        (HDW_W),
    .CFG_W        (CFG_W),
    .DEF_LINE_GRAY(DEF_LINE_GRAY),
    .DEF_FIELD    (DEF_FIELD),
    .DEF_HDW      (DEF_HDW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .load     (frame_start),
    .pix_last (pix_last),
    .line_last(line_last),
    .hd_width (hd_width),
    .master   (master)
  );

  sg_counters #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (sync_rise | vd_evt),
    .line_step  (hd_evt),
    .pix_last   (pix_last),
    .line_last  (line_last),
    .pix_cnt    (pix_cnt_o),
    .line_cnt   (line_cnt_o),
    .pix_wrap   (pix_wrap),
    .frame_start(frame_start)
  );

  assign hd_n_o     = ~(pix_cnt_o < {{(PIX_W-HDW_W){1'b0}}, hd_width});
  assign vd_n_o     = (line_cnt_o != '0);
  assign hv_drive_o = master;
endmodule

// File: rtl/sensor_sync_gen_chk.sv
module sensor_sync_gen_chk #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_rise,
  input logic              hd_evt,
  input logic              vd_evt,
  input logic              frame_start,
  input logic              pix_wrap,
  input logic [PIX_W-1:0]  pix_last,
  input logic [LINE_W-1:0] line_last,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              vd_n_o
);
  logic quiet;
  assign quiet = !sync_rise && !vd_evt && !hd_evt && !pix_wrap;

  a_r2_pix_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt <= pix_last);

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> pix_cnt == $past(pix_cnt) + 1'b1);

  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(line_cnt));

  a_r5_vd_at_field_top: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vd_n_o) |-> pix_cnt == '0);

  a_r7_hd_restarts_line: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_evt && !sync_rise && !vd_evt) |=> pix_cnt == '0);

  a_r8_vd_restarts_field: assert property (@(posedge clk) disable iff (!rst_n)
    vd_evt |=> (pix_cnt == '0 && line_cnt == '0));

  a_r9_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (pix_cnt == '0 && line_cnt == '0));

  a_r10_lengths_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(pix_last) && $stable(line_last)));
endmodule

bind sensor_sync_gen sensor_sync_gen_chk #(
  .PIX_W (PIX_W),
  .LINE_W(LINE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_rise  (sync_rise),
  .hd_evt     (hd_evt),
  .vd_evt     (vd_evt),
  .frame_start(frame_start),
  .pix_wrap   (pix_wrap),
  .pix_last   (pix_last),
  .line_last  (line_last),
  .pix_cnt    (pix_cnt_o),
  .line_cnt   (line_cnt_o),
  .vd_n_o     (vd_n_o)
);

// File: tb/test_sensor_sync_gen.sv
`timescale 1ns/1ps
module test_sensor_sync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [11:0] cfg_wdata = 12'd0;
  logic        sync_i = 1'b0;
  logic        hd_n_i = 1'b1;
  logic        vd_n_i = 1'b1;
  logic        hd_n_o, vd_n_o, hv_drive_o;
  logic [11:0] pix_cnt_o, line_cnt_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  sensor_sync_gen i_sensor_sync_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_i(sync_i), .hd_n_i(hd_n_i), .vd_n_i(vd_n_i),
    .hd_n_o(hd_n_o), .vd_n_o(vd_n_o), .hv_drive_o(hv_drive_o),
    .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o)
  );

  function automatic logic [11:0] to_gray(input int b);
    logic [11:0] v = 12'(b);
    return v ^ (v >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Pulse sync_i; returns at the falling edge where counters read 0.
  task automatic sync_pulse();
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Walk an independent model: k-th cycle since field start.
  task automatic run_check(input int len, input int lines, input int w,
                           input int k0, input int n, input string req);
    int weff = (w == 0) ? 1 : w;
    int nl = (lines == 0) ? 1 : lines;
    for (int i = 0; i < n; i++) begin
      int k = k0 + i;
      int ep = k % len;
      int el = (k / len) % nl;
      chk(pix_cnt_o == 12'(ep), req, "pixel", int'(pix_cnt_o), ep);
      chk(line_cnt_o == 12'(el), req, "line", int'(line_cnt_o), el);
      chk(hd_n_o == !(ep < weff), req, "hd_n_o", int'(hd_n_o), int'(!(ep < weff)));
      chk(vd_n_o == (el != 0), req, "vd_n_o", int'(vd_n_o), int'(el != 0));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(hv_drive_o == 1'b0, "R1", "hv_drive_o", int'(hv_drive_o), 0);
    chk(pix_cnt_o == 0, "R1", "pixel", int'(pix_cnt_o), 0);
    chk(line_cnt_o == 0, "R1", "line", int'(line_cnt_o), 0);
    chk(hd_n_o == 1'b0, "R1", "hd_n_o", int'(hd_n_o), 0);
    chk(vd_n_o == 1'b0, "R1", "vd_n_o", int'(vd_n_o), 0);
  endtask

  task automatic t_mode();
    wr(2'd3, 12'd1);
    chk(hv_drive_o == 1'b1, "R6", "master", int'(hv_drive_o), 1);
    wr(2'd3, 12'd0);
    chk(hv_drive_o == 1'b0, "R6", "slave", int'(hv_drive_o), 0);
    wr(2'd3, 12'd1);
  endtask

  task automatic t_master_basic();
    wr(2'd0, to_gray(6));   // 10 pixels
    wr(2'd1, 12'd3);
    wr(2'd2, 12'd3);
    sync_pulse();
    run_check(10, 3, 3, 0, 65, "R2 R3 R4 R5");
  endtask

  task automatic t_deferred();
    sync_pulse();
    run_check(10, 3, 3, 0, 5, "R10");
    wr(2'd0, to_gray(10));  // 14 pixels, held until field start
    wr(2'd1, 12'd2);
    run_check(10, 3, 3, 7, 23, "R10 old lengths");
    run_check(14, 2, 3, 0, 60, "R10 new lengths");
  endtask

  task automatic t_gray_example();
    wr(2'd0, 12'h51E);
    sync_pulse();
    run_check(1560, 2, 3, 0, 1565, "R2 0x51E");
  endtask

  task automatic t_saturate();
    wr(2'd0, 12'h800);      // decodes to 4095
    sync_pulse();
    run_check(4096, 2, 3, 0, 4100, "R11");
  endtask

  task automatic t_zero_fields();
    wr(2'd0, to_gray(6));
    wr(2'd1, 12'd0);
    wr(2'd2, 12'd0);
    sync_pulse();
    run_check(10, 1, 1, 0, 35, "R3 R4 zero");
    wr(2'd0, to_gray(16));  // 20 pixels
    wr(2'd2, 12'd15);
    sync_pulse();
    run_check(20, 1, 15, 0, 45, "R4 width 15");
  endtask

  task automatic t_slave();
    wr(2'd3, 12'd0);
    wr(2'd0, to_gray(6));
    wr(2'd1, 12'd3);
    wr(2'd2, 12'd3);
    sync_pulse();
    run_check(10, 3, 3, 0, 4, "R9 slave");
    hd_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_cnt_o == 0, "R7 R12", "pixel after HD", int'(pix_cnt_o), 0);
    chk(line_cnt_o == 1, "R7", "line after HD", int'(line_cnt_o), 1);
    @(negedge clk);
    chk(pix_cnt_o == 1, "R7", "resume", int'(pix_cnt_o), 1);
    hd_n_i = 1'b1;
    run_check(10, 3, 3, 11, 15, "R7 rise ignored");
    vd_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_cnt_o == 0, "R8 R12", "pixel after VD", int'(pix_cnt_o), 0);
    chk(line_cnt_o == 0, "R8", "line after VD", int'(line_cnt_o), 0);
    vd_n_i = 1'b1;
    run_check(10, 3, 3, 0, 12, "R8 resume");
  endtask

  task automatic t_priority();
    run_check(10, 3, 3, 12, 3, "R9 pre");   // now at pix 5, line 1
    hd_n_i = 1'b0;
    sync_pulse();
    chk(pix_cnt_o == 0, "R9", "pixel sync+HD", int'(pix_cnt_o), 0);
    chk(line_cnt_o == 0, "R9", "line sync+HD", int'(line_cnt_o), 0);
    hd_n_i = 1'b1;
    run_check(10, 3, 3, 0, 7, "R9 post");   // now at pix 7
    sync_pulse();                            // lands on the natural line end
    chk(pix_cnt_o == 0, "R9", "pixel sync@wrap", int'(pix_cnt_o), 0);
    chk(line_cnt_o == 0, "R9", "line sync@wrap", int'(line_cnt_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mode();
    t_master_basic();
    t_deferred();
    t_gray_example();
    t_saturate();
    t_zero_fields();
    t_slave();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule